// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates interrupt requests for an 8-bit microcontroller core. Six sources report through raw flag inputs. Two of the sources are merged from flag pairs: the serial channel (receive or transmit) and the second timer (overflow or external reload). A small special-function-register port holds an enable register and a level register. Software uses them to mask sources, to set the global enable, and to place each source at the low or high level.

Once per machine cycle, on the `cycle_tick` strobe, the merged flags are captured into a sample register. An arbiter looks at that sample, the enables and the levels, and picks one winner. High-level candidates beat low-level ones. Within a level, a fixed polling order decides. When the core signals an instruction boundary, the winner is acknowledged with a one-cycle pulse and its call target. The block records the level now in service, so that only a strictly higher level can preempt. A return strobe from the core releases the innermost level.

The block also pulses a hardware-clear line for the external and basic timer sources. The serial and second-timer flags stay set until software clears them at their origin.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, both registers read 00h, nothing is in service, the sample is empty, and `ack_pulse`, `ack_vector` and `flag_clr` are 0.
- R2: The enable register (`sfr_sel`=0) holds the global enable in bit 7. Bits 5..0 enable source indices 5..0. Bit 6 always reads 0. Readback appears on `sfr_rdata` one clock after `sfr_sel` is applied.
- R3: The level register (`sfr_sel`=1) holds bits 5..0, one per source index, where 1 means high level. Bits 7 and 6 always read 0.
- R4: A source takes part in arbitration only if its enable bit and the global enable are both 1. A set flag with either bit cleared never produces an acknowledge.
- R5: The arbiter sees only the value captured at the most recent `cycle_tick` edge. Flag activity between ticks is invisible.
- R6: `ack_pulse` rises for one clock, in the clock after an edge where `insn_boundary` is 1 and a request is eligible. It never rises without `insn_boundary`.
- R7: `ack_vector` equals 0003h + 8 × index while `ack_pulse` is 1, and 0 otherwise. The index order is: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2.
- R8: An eligible high-level source beats every low-level source. Within one level, the lowest index wins.
- R9: No acknowledge is given while the high level is in service. While only the low level is in service, only a high-level request is acknowledged.
- R10: A `reti_strobe` clears the high in-service bit if it is set, and otherwise clears the low bit. No acknowledge is taken at an edge where `reti_strobe` is 1.
- R11: Raw flag bits are laid out as [0] ext0, [1] tmr0, [2] ext1, [3] tmr1, [4] serial rx, [5] serial tx, [6] timer 2 overflow, [7] timer 2 reload. Source 4 is bit 4 OR bit 5, and source 5 is bit 6 OR bit 7.
- R12: `flag_clr` bit i (i = 0..3) pulses together with an acknowledge of source i. Acknowledges of sources 4 and 5 leave `flag_clr` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_we | input | 1 | Register write strobe |
| sfr_sel | input | 1 | Register select: 0 enable, 1 level |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Registered readback of the selected register |
| raw_flags | input | 8 | Source flags from the peripherals |
| cycle_tick | input | 1 | Machine-cycle sampling strobe |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| reti_strobe | input | 1 | Return-from-interrupt strobe |
| ack_pulse | output | 1 | One-clock acknowledge (forced call) |
| ack_vector | output | 16 | Call target for the acknowledged source |
| flag_clr | output | 4 | Hardware clear for ext0, tmr0, ext1, tmr1 flags |

## Verification
Directed cases come first:
- A flag that is present but not ticked tells sampling apart from raw flag visibility.
- Transmit-only, receive-only and reload-only flags show that each half of a merged pair reaches arbitration on its own.
- All flags set with the global enable off separates global masking from per-source masking.
- Mixed-level flag sets with a low routine already running show whether the design tells preemption from equal-level blocking.
- A return strobe at the same edge as a boundary tells apart the ordering of release and acknowledge.

Random register values, flag sets and return strobes then drive the design against a reference arbitration model. That model tracks sample, in-service and level state in the bench.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int unsigned SRC_N  = 6;
  localparam int unsigned IDX_W  = $clog2(SRC_N);
  localparam int unsigned HWCLR_N = 4;

  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_LEVEL  = 1'b1
  } sfr_sel_e;

  typedef struct packed {
    logic             valid;
    logic             hi;
    logic [IDX_W-1:0] idx;
  } grant_t;

endpackage

// File: rtl/irq_sfr_regs.sv
module irq_sfr_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NSRC   = SRC_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NSRC-1:0]   src_en,
  output logic              glob_en,
  output logic [NSRC-1:0]   src_hi
);

  localparam int unsigned GLOB_BIT = DATA_W - 1;

  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] lvl_q;
  logic            ea_q;
  logic [DATA_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      lvl_q <= '0;
      ea_q  <= 1'b0;
    end else if (we) begin
      if (sfr_sel_e'(sel) == SEL_ENABLE) begin
        en_q <= wdata[NSRC-1:0];
        ea_q <= wdata[GLOB_BIT];
      end else begin
        lvl_q <= wdata[NSRC-1:0];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (sfr_sel_e'(sel) == SEL_ENABLE) begin
      rd_next[NSRC-1:0] = en_q;
      rd_next[GLOB_BIT] = ea_q;
    end else begin
      rd_next[NSRC-1:0] = lvl_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  assign src_en  = en_q;
  assign glob_en = ea_q;
  assign src_hi  = lvl_q;

endmodule

// File: rtl/irq_sampler.sv
module irq_sampler
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned RAW_N = 8,
  parameter int unsigned NSRC  = SRC_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [RAW_N-1:0] raw,
  output logic [NSRC-1:0]  samp
);

  localparam int unsigned PLAIN_N = NSRC - 2;

  logic [NSRC-1:0] merged;

  always_comb begin
    merged = '0;
    merged[PLAIN_N-1:0] = raw[PLAIN_N-1:0];
    merged[PLAIN_N]     = raw[PLAIN_N]     | raw[PLAIN_N + 1];
    merged[PLAIN_N + 1] = raw[PLAIN_N + 2] | raw[PLAIN_N + 3];
  end

  always_ff @(posedge clk) begin
    if (rst)       samp <= '0;
    else if (tick) samp <= merged;
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NSRC = SRC_N
) (
  input  logic [NSRC-1:0] samp,
  input  logic [NSRC-1:0] src_en,
  input  logic            glob_en,
  input  logic [NSRC-1:0] src_hi,
  input  logic            ins_hi,
  input  logic            ins_lo,
  output grant_t          grant
);

  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] req_hi;
  logic [NSRC-1:0] req_lo;
  logic [IDX_W-1:0] idx_hi, idx_lo;
  logic any_hi, any_lo;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_req
      assign elig[g]   = samp[g] & src_en[g] & glob_en;
      assign req_hi[g] = elig[g] & src_hi[g];
      assign req_lo[g] = elig[g] & ~src_hi[g];
    end
  endgenerate

  always_comb begin
    idx_hi = '0;
    idx_lo = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_hi[i]) idx_hi = IDX_W'(i);
      if (req_lo[i]) idx_lo = IDX_W'(i);
    end
  end

  assign any_hi = |req_hi;
  assign any_lo = |req_lo;

  always_comb begin
    grant = '0;
    if (any_hi && !ins_hi) begin
      grant.valid = 1'b1;
      grant.hi    = 1'b1;
      grant.idx   = idx_hi;
    end else if (any_lo && !ins_hi && !ins_lo) begin
      grant.valid = 1'b1;
      grant.hi    = 1'b0;
      grant.idx   = idx_lo;
    end
  end

endmodule

// File: rtl/irq_service_track.sv
module irq_service_track
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter int unsigned VEC_STEP = 8,
  parameter int unsigned NCLR     = HWCLR_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boundary,
  input  logic             reti,
  input  grant_t           grant,
  output logic             ack,
  output logic [VEC_W-1:0] vector,
  output logic [NCLR-1:0]  clr,
  output logic             ins_hi,
  output logic             ins_lo
);

  logic take;
  logic [VEC_W-1:0] vec_calc;
  logic [NCLR-1:0]  clr_calc;

  assign take     = boundary & grant.valid & ~reti;
  assign vec_calc = VEC_W'(VEC_BASE) + VEC_W'(grant.idx) * VEC_W'(VEC_STEP);

  always_comb begin
    clr_calc = '0;
    for (int i = 0; i < NCLR; i++) begin
      if (grant.idx == IDX_W'(i)) clr_calc[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
    end else if (reti) begin
      if (ins_hi) ins_hi <= 1'b0;
      else        ins_lo <= 1'b0;
    end else if (take) begin
      if (grant.hi) ins_hi <= 1'b1;
      else          ins_lo <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack    <= 1'b0;
      vector <= '0;
      clr    <= '0;
    end else begin
      ack    <= take;
      vector <= take ? vec_calc : '0;
      clr    <= take ? clr_calc : '0;
    end
  end

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RAW_N    = 8,
  parameter int unsigned VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sfr_we,
  input  logic              sfr_sel,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic [RAW_N-1:0]  raw_flags,
  input  logic              cycle_tick,
  input  logic              insn_boundary,
  input  logic              reti_strobe,
  output logic              ack_pulse,
  output logic [VEC_W-1:0]  ack_vector,
  output logic [HWCLR_N-1:0] flag_clr
);

  logic [SRC_N-1:0] src_en, src_hi, samp;
  logic             glob_en;
  logic             ins_hi, ins_lo;
  grant_t           grant;

  irq_sfr_regs #(.DATA_W(DATA_W), .NSRC(SRC_N)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (sfr_we),
    .sel     (sfr_sel),
    .wdata   (sfr_wdata),
    .rdata   (sfr_rdata),
    .src_en  (src_en),
    .glob_en (glob_en),
    .src_hi  (src_hi)
  );

  irq_sampler #(.RAW_N(RAW_N), .NSRC(SRC_N)) u_samp (
    .clk  (clk),
    .rst  (rst),
    .tick (cycle_tick),
    .raw  (raw_flags),
    .samp (samp)
  );

  irq_arbiter #(.NSRC(SRC_N)) u_arb (
    .samp    (samp),
    .src_en  (src_en),
    .glob_en (glob_en),
    .src_hi  (src_hi),
    .ins_hi  (ins_hi),
    .ins_lo  (ins_lo),
    .grant   (grant)
  );

  irq_service_track #(
    .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP), .NCLR(HWCLR_N)
  ) u_svc (
    .clk      (clk),
    .rst      (rst),
    .boundary (insn_boundary),
    .reti     (reti_strobe),
    .grant    (grant),
    .ack      (ack_pulse),
    .vector   (ack_vector),
    .clr      (flag_clr),
    .ins_hi   (ins_hi),
    .ins_lo   (ins_lo)
  );

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        ack_pulse,
  input logic [15:0] ack_vector,
  input logic [3:0]  flag_clr,
  input logic        insn_boundary,
  input logic        reti_strobe,
  input logic        ins_hi,
  input logic        ins_lo,
  input logic        glob_en
);

  a_r6_ack_needs_boundary: assert property (@(posedge clk) disable iff (rst)
    ack_pulse |-> $past(insn_boundary));

  a_r4_ack_needs_global: assert property (@(posedge clk) disable iff (rst)
    ack_pulse |-> $past(glob_en));

  a_r10_no_ack_on_return: assert property (@(posedge clk) disable iff (rst)
    ack_pulse |-> !$past(reti_strobe));

  a_r10_return_drops_high: assert property (@(posedge clk) disable iff (rst)
    (reti_strobe && ins_hi) |=> !ins_hi);

  a_r9_high_blocks_all: assert property (@(posedge clk) disable iff (rst)
    ack_pulse |-> !$past(ins_hi));

  a_r9_nest_only_high: assert property (@(posedge clk) disable iff (rst)
    (ack_pulse && $past(ins_lo)) |-> ins_hi);

  a_r7_vector_on_grid: assert property (@(posedge clk) disable iff (rst)
    ack_pulse |-> (ack_vector[2:0] == 3'b011 && ack_vector <= 16'h002B));

  a_r7_vector_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !ack_pulse |-> ack_vector == 16'h0000);

  a_r12_clear_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flag_clr));

  a_r12_clear_with_ack: assert property (@(posedge clk) disable iff (rst)
    (flag_clr != 4'b0000) |-> ack_pulse);

endmodule

bind irq_ctrl_top irq_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .ack_pulse     (ack_pulse),
  .ack_vector    (ack_vector),
  .flag_clr      (flag_clr),
  .insn_boundary (insn_boundary),
  .reti_strobe   (reti_strobe),
  .ins_hi        (ins_hi),
  .ins_lo        (ins_lo),
  .glob_en       (glob_en)
);

// File: tb/sim_irq_ctrl_top.sv
`timescale 1ns/1ps
module sim_irq_ctrl_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sfr_we = 1'b0;
  logic        sfr_sel = 1'b0;
  logic [7:0]  sfr_wdata = '0;
  logic [7:0]  sfr_rdata;
  logic [7:0]  raw_flags = '0;
  logic        cycle_tick = 1'b0;
  logic        insn_boundary = 1'b0;
  logic        reti_strobe = 1'b0;
  logic        ack_pulse;
  logic [15:0] ack_vector;
  logic [3:0]  flag_clr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // bench-side model state
  logic [7:0] m_ie = '0, m_ip = '0;
  logic [5:0] m_samp = '0;
  logic       m_hi = 1'b0, m_lo = 1'b0;

  always #5 clk = ~clk;

  irq_ctrl_top u0 (
    .clk(clk), .rst(rst), .sfr_we(sfr_we), .sfr_sel(sfr_sel),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .raw_flags(raw_flags),
    .cycle_tick(cycle_tick), .insn_boundary(insn_boundary),
    .reti_strobe(reti_strobe), .ack_pulse(ack_pulse),
    .ack_vector(ack_vector), .flag_clr(flag_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] merge(input logic [7:0] r);
    return {r[6] | r[7], r[4] | r[5], r[3:0]};
  endfunction

  // returns -1 for none, else idx + 8 when high level
  function automatic int pick(input logic [5:0] s, input logic [7:0] ie,
                              input logic [7:0] ip, input logic hi, input logic lo);
    logic [5:0] el;
    el = s & ie[5:0] & {6{ie[7]}};
    if (!hi) for (int i = 0; i < 6; i++) if (el[i] && ip[i]) return i + 8;
    if (!hi && !lo) for (int i = 0; i < 6; i++) if (el[i] && !ip[i]) return i;
    return -1;
  endfunction

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    sfr_we = 1'b1; sfr_sel = sel; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
    if (sel) m_ip = d & 8'h3F; else m_ie = d & 8'hBF;
  endtask

  task automatic rd_check(input string req, input logic sel);
    @(negedge clk);
    sfr_sel = sel;
    @(negedge clk);
    chk(req, sfr_rdata, sel ? m_ip : m_ie);
  endtask

  task automatic tick(input logic [7:0] r);
    @(negedge clk);
    raw_flags = r; cycle_tick = 1'b1;
    @(negedge clk);
    cycle_tick = 1'b0; raw_flags = '0;
    m_samp = merge(r);
    chk("R1 idle-ack", ack_pulse, 0);
  endtask

  // one edge with the given boundary / return strobes, then check outputs
  task automatic step(input string req, input logic b, input logic r);
    int p;
    logic [15:0] ev;
    logic [3:0]  ec;
    p = (b && !r) ? pick(m_samp, m_ie, m_ip, m_hi, m_lo) : -1;
    @(negedge clk);
    insn_boundary = b; reti_strobe = r;
    @(negedge clk);
    insn_boundary = 1'b0; reti_strobe = 1'b0;
    if (r) begin
      if (m_hi) m_hi = 1'b0; else m_lo = 1'b0;
    end
    ev = '0; ec = '0;
    if (p >= 0) begin
      ev = 16'h0003 + 16'((p % 8) * 8);
      if ((p % 8) < 4) ec[p % 8] = 1'b1;
      if (p >= 8) m_hi = 1'b1; else m_lo = 1'b1;
    end
    chk({req, " ack"}, ack_pulse, (p >= 0));
    chk({req, " vector"}, ack_vector, ev);
    chk({req, " clr"}, flag_clr, ec);
  endtask

  task automatic release_all();
    step("R10 release", 1'b0, 1'b1);
    step("R10 release", 1'b0, 1'b1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1C0FFEE);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ack", ack_pulse, 0);
    chk("R1 vector", ack_vector, 0);
    chk("R1 clr", flag_clr, 0);
    rd_check("R1 enable reset", 1'b0);
    rd_check("R1 level reset", 1'b1);
    // R2 / R3 unused bits
    wr(1'b0, 8'hFF); rd_check("R2 enable bit6", 1'b0);
    wr(1'b1, 8'hFF); rd_check("R3 level bits7:6", 1'b1);
    wr(1'b1, 8'h00);
    // R5 unticked flag is invisible
    wr(1'b0, 8'h81);
    @(negedge clk); raw_flags = 8'h01;
    step("R5 no tick", 1'b1, 1'b0);
    raw_flags = 8'h00;
    tick(8'h01);
    step("R6 R7 R12 ext0", 1'b0, 1'b0);
    step("R6 R7 R12 ext0", 1'b1, 1'b0);
    step("R9 low blocks low", 1'b1, 1'b0);
    step("R10 same edge", 1'b1, 1'b1);
    step("R10 after release", 1'b1, 1'b0);
    release_all();
    // R4 global enable off
    wr(1'b0, 8'h3F); tick(8'hFF);
    step("R4 global off", 1'b1, 1'b0);
    wr(1'b0, 8'hBE); tick(8'h01);
    step("R4 source off", 1'b1, 1'b0);
    // R11 merged pairs
    wr(1'b0, 8'h90); tick(8'h20); step("R11 tx only", 1'b1, 1'b0); release_all();
    tick(8'h10); step("R11 rx only", 1'b1, 1'b0); release_all();
    wr(1'b0, 8'hA0); tick(8'h80); step("R11 reload only", 1'b1, 1'b0); release_all();
    tick(8'h40); step("R11 overflow only", 1'b1, 1'b0); release_all();
    // R8 ordering
    wr(1'b0, 8'hBF); tick(8'h0C); step("R8 low order", 1'b1, 1'b0); release_all();
    wr(1'b1, 8'h20); tick(8'hC1); step("R8 high wins", 1'b1, 1'b0);
    step("R9 high blocks all", 1'b1, 1'b0); release_all();
    // R9 preemption of a running low routine
    tick(8'h01); step("R9 low start", 1'b1, 1'b0);
    tick(8'h03); step("R9 equal blocked", 1'b1, 1'b0);
    tick(8'h41); step("R9 preempt", 1'b1, 1'b0);
    step("R10 drop high", 1'b0, 1'b1);
    tick(8'h02); step("R10 low still held", 1'b1, 1'b0);
    release_all();
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 0) wr(1'b0, 8'($urandom));
      if (r[7:4] == 0) wr(1'b1, 8'($urandom));
      if (r[9:8] != 0) tick(8'($urandom) & 8'($urandom));
      step("R8 R9 R10 random", r[10] | r[11], r[12] & r[13]);
      if (r[15:14] == 0) rd_check("R2 R3 random read", r[16]);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule